// File: doc/BRIEF.md
# Z80 Bus Window Bridge

This block sits between a 24-bit host bus of the 68000 kind and a Z80 sound subsystem. It decodes host byte and word cycles into three control registers: a bus-request register that halts or frees the Z80, a reset-control register, and a 9-bit bank register that sets the page the Z80 sees when it reaches into host space. It also opens an 8 KB window onto the RAM that the two processors share. The RAM is kept outside the block behind a simple port. The bridge produces the address, byte data and write strobe for it, and it takes the read byte back.

The host may touch the shared RAM only while it holds the Z80 off the bus. While the Z80 runs, host writes to the window are dropped and host reads of the window return zero. The bank register is loaded one bit per write. Each write shifts the register down by one place and puts the new bit at the top, so nine writes load a full page number.

Host reads are combinational from the address and the current state. Register writes take effect at the clock edge on which `host_wr` is sampled high.

Top module: `z80win_bridge`

## Requirements
- R1: After reset the Z80 is running (`z80_busreq`=0), is held in reset (`z80_reset_n`=0), and `z80_bank` is 0.
- R2: A write to 0xA11100 sets the run flag to the inverse of the control bit. The control bit is data bit 0 for a byte write and data bit 8 for a word write. `z80_busreq` is the inverse of the run flag, so writing a 1 halts the Z80.
- R3: A read of 0xA11100 returns 0x80 OR the run flag in bits 15:8, and 0x00 in bits 7:0.
- R4: A write to 0xA11200 whose control bit (bit 0 for a byte write, bit 8 for a word write) is 0 drives `z80_reset_n` low. A control bit of 1 drives it high.
- R5: A bank write shifts `z80_bank` right by one and loads data bit 0 into bit 8, for byte and word writes alike.
- R6: A write is a bank write when its address ANDed with 0xFF7F00 equals 0xA06000. Address bit 15 and bits 7:0 are ignored, and any other address leaves `z80_bank` unchanged.
- R7: Addresses 0xA00000 to 0xA03FFF form the RAM window. `ram_addr` is address bits 12:0, so 0xA02000 and up alias onto 0xA00000 and up.
- R8: While the run flag is 1, a host write to the RAM window keeps `ram_we` low and the stored byte is unchanged.
- R9: While the Z80 is halted, a window write raises `ram_we`. A byte write stores data bits 7:0. A word write stores data bits 15:8 only.
- R10: A window read returns 0x0000 while the Z80 runs. While it is halted, the read returns the RAM byte in both bytes of `host_rdata`.
- R11: Reads of 0xA06000 to 0xA0FFFF return 0xFFFF. Reads of any other undecoded address, and all cycles without `host_rd`, return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 24 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_word | input | 1 | 1 for a word cycle, 0 for a byte cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read enable |
| host_rdata | output | 16 | Host read data, combinational |
| ram_addr | output | 13 | Shared RAM byte address |
| ram_we | output | 1 | Shared RAM write strobe |
| ram_wdata | output | 8 | Shared RAM write byte |
| ram_rdata | input | 8 | Shared RAM read byte |
| z80_busreq | output | 1 | 1 while the host holds the Z80 off the bus |
| z80_reset_n | output | 1 | Z80 reset, active low |
| z80_bank | output | 9 | Host address bits 23:15 for Z80 accesses into host space |

## Verification
The bench writes the control registers with both byte and word cycles. A design that took the control bit from the wrong byte lane would then show the opposite run or reset state. It sends bank writes to a mirrored address with bit 15 set and to an address with bit 8 set. A mask that is too loose, or too strict, would then add or drop a bit in the shifted page. It writes to the shared RAM while the Z80 runs and reads the same byte back after halting it, which shows a write gate that leaks. It also reads at the edges of the window and of the fill region, where a sloppy decode would return RAM data, zero or all ones in the wrong place.

// File: rtl/z80win_pkg.sv
`timescale 1ns/1ps
package z80win_pkg;
  localparam int HOST_AW = 24;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RAM, SEL_BUSREQ, SEL_RSTCTL, SEL_BANK, SEL_FILL
  } sel_e;

  // control bit: low byte lane for byte cycles, high lane for word cycles
  function automatic logic ctl_bit(input logic [15:0] d, input logic word);
    return word ? d[8] : d[0];
  endfunction

  // byte that reaches the shared RAM: word cycles keep only the upper byte
  function automatic logic [7:0] ram_byte(input logic [15:0] d, input logic word);
    return word ? d[15:8] : d[7:0];
  endfunction

  // status word for a bus-request read
  function automatic logic [15:0] status_word(input logic run);
    return {1'b1, 6'b0, run, 8'h00};
  endfunction

  // replicate a RAM byte into both halves
  function automatic logic [15:0] mirror_byte(input logic [7:0] b);
    return {b, b};
  endfunction
endpackage

// File: rtl/z80win_decode.sv
`timescale 1ns/1ps
module z80win_decode
  import z80win_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] addr,
  output sel_e          wsel,
  output sel_e          rsel
);
  localparam logic [AW-1:0] A_BUSREQ = AW'(24'hA11100);
  localparam logic [AW-1:0] A_RSTCTL = AW'(24'hA11200);
  localparam logic [AW-1:0] M_BANK   = AW'(24'hFF7F00);
  localparam logic [AW-1:0] A_BANK   = AW'(24'hA06000);
  localparam logic [AW-1:0] M_WIN    = AW'(24'hFFC000);
  localparam logic [AW-1:0] A_WIN    = AW'(24'hA00000);
  localparam logic [AW-1:0] M_REGION = AW'(24'hFF0000);

  logic hit_busreq, hit_rstctl, hit_bank, hit_win, hit_fill;

  always_comb begin
    hit_busreq = (addr == A_BUSREQ);
    hit_rstctl = (addr == A_RSTCTL);
    hit_bank   = ((addr & M_BANK) == A_BANK);
    hit_win    = ((addr & M_WIN) == A_WIN);
    hit_fill   = ((addr & M_REGION) == A_WIN) && (addr[15:13] >= 3'd3);
  end

  always_comb begin
    wsel = SEL_NONE;
    if (hit_busreq)      wsel = SEL_BUSREQ;
    else if (hit_rstctl) wsel = SEL_RSTCTL;
    else if (hit_bank)   wsel = SEL_BANK;
    else if (hit_win)    wsel = SEL_RAM;
  end

  always_comb begin
    rsel = SEL_NONE;
    if (hit_busreq)    rsel = SEL_BUSREQ;
    else if (hit_win)  rsel = SEL_RAM;
    else if (hit_fill) rsel = SEL_FILL;
  end
endmodule

// File: rtl/z80win_ctrl.sv
`timescale 1ns/1ps
module z80win_ctrl
  import z80win_pkg::*;
#(
  parameter int BANK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  sel_e              wsel,
  input  logic [15:0]       wdata,
  input  logic              word,
  output logic              run,
  output logic              hold,
  output logic [BANK_W-1:0] bank,
  output logic              ev_busreq,
  output logic              ev_rstctl,
  output logic              ev_bank
);
  logic cbit;

  always_comb begin
    cbit      = ctl_bit(wdata, word);
    ev_busreq = wr && (wsel == SEL_BUSREQ);
    ev_rstctl = wr && (wsel == SEL_RSTCTL);
    ev_bank   = wr && (wsel == SEL_BANK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b1;
      hold <= 1'b1;
      bank <= '0;
    end else begin
      if (ev_busreq) run  <= ~cbit;
      if (ev_rstctl) hold <= ~cbit;
      if (ev_bank)   bank <= {wdata[0], bank[BANK_W-1:1]};
    end
  end
endmodule

// File: rtl/z80win_rdmux.sv
`timescale 1ns/1ps
module z80win_rdmux
  import z80win_pkg::*;
(
  input  logic        rd,
  input  sel_e        rsel,
  input  logic        run,
  input  logic [7:0]  ram_rdata,
  output logic [15:0] rdata
);
  always_comb begin
    rdata = 16'h0000;
    if (rd) begin
      unique case (rsel)
        SEL_BUSREQ: rdata = status_word(run);
        SEL_RAM:    rdata = run ? 16'h0000 : mirror_byte(ram_rdata);
        SEL_FILL:   rdata = 16'hFFFF;
        default:    rdata = 16'h0000;
      endcase
    end
  end
endmodule

// File: rtl/z80win_bridge.sv
`timescale 1ns/1ps
module z80win_bridge
  import z80win_pkg::*;
#(
  parameter int AW     = 24,
  parameter int RAM_AW = 13,
  parameter int BANK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     host_addr,
  input  logic [15:0]       host_wdata,
  input  logic              host_word,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [15:0]       host_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              z80_busreq,
  output logic              z80_reset_n,
  output logic [BANK_W-1:0] z80_bank
);
  sel_e wsel, rsel;
  logic run, hold;
  logic ev_busreq, ev_rstctl, ev_bank;
  logic ev_ram_drop;

  z80win_decode #(.AW(AW)) u_dec (
    .addr (host_addr),
    .wsel (wsel),
    .rsel (rsel)
  );

  z80win_ctrl #(.BANK_W(BANK_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (host_wr),
    .wsel      (wsel),
    .wdata     (host_wdata),
    .word      (host_word),
    .run       (run),
    .hold      (hold),
    .bank      (z80_bank),
    .ev_busreq (ev_busreq),
    .ev_rstctl (ev_rstctl),
    .ev_bank   (ev_bank)
  );

  z80win_rdmux u_rd (
    .rd        (host_rd),
    .rsel      (rsel),
    .run       (run),
    .ram_rdata (ram_rdata),
    .rdata     (host_rdata)
  );

  always_comb begin
    ram_addr    = host_addr[RAM_AW-1:0];
    ram_wdata   = ram_byte(host_wdata, host_word);
    ram_we      = host_wr && (wsel == SEL_RAM) && !run;
    ev_ram_drop = host_wr && (wsel == SEL_RAM) && run;
    z80_busreq  = ~run;
    z80_reset_n = ~hold;
  end
endmodule

// File: rtl/z80win_chk.sv
`timescale 1ns/1ps
module z80win_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] host_addr,
  input logic [15:0] host_wdata,
  input logic        host_word,
  input logic        host_wr,
  input logic        host_rd,
  input logic [15:0] host_rdata,
  input logic        ram_we,
  input logic        z80_busreq,
  input logic        z80_reset_n,
  input logic [8:0]  z80_bank,
  input logic        ev_ram_drop
);
  logic cb, is_busreq, is_rst, is_bank, is_win, is_fill;
  always_comb begin
    cb        = host_word ? host_wdata[8] : host_wdata[0];
    is_busreq = host_addr == 24'hA11100;
    is_rst    = host_addr == 24'hA11200;
    is_bank   = (host_addr[23:16] == 8'hA0) && (host_addr[14:8] == 7'h60);
    is_win    = (host_addr[23:16] == 8'hA0) && (host_addr[15:14] == 2'b00);
    is_fill   = (host_addr[23:16] == 8'hA0) && (host_addr[15:13] > 3'd2);
  end

  // R2
  busreq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && is_busreq) |=> (z80_busreq == $past(cb)));

  // R4
  reset_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && is_rst) |=> (z80_reset_n == $past(cb)));

  // R5
  bank_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && is_bank) |=> (z80_bank == {$past(host_wdata[0]), $past(z80_bank[8:1])}));

  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && is_bank) |=> $stable(z80_bank));

  // R8
  ram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (z80_busreq && !ev_ram_drop));

  // R10
  ram_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && is_win && !z80_busreq) |-> (host_rdata == 16'h0000));

  // R11
  fill_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && is_fill) |-> (host_rdata == 16'hFFFF));
endmodule

bind z80win_bridge z80win_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_word   (host_word),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_rdata  (host_rdata),
  .ram_we      (ram_we),
  .z80_busreq  (z80_busreq),
  .z80_reset_n (z80_reset_n),
  .z80_bank    (z80_bank),
  .ev_ram_drop (ev_ram_drop)
);

// File: tb/z80win_bridge_bench.sv
`timescale 1ns/1ps
module z80win_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_word = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_rdata;
  logic [12:0] ram_addr;
  logic        ram_we;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;
  logic        z80_busreq, z80_reset_n;
  logic [8:0]  z80_bank;
  logic [7:0]  mem [256];
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  z80win_bridge u_z80win_bridge (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_word(host_word), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .z80_busreq(z80_busreq),
    .z80_reset_n(z80_reset_n), .z80_bank(z80_bank)
  );

  // small RAM model on the low 8 address bits
  assign ram_rdata = mem[ram_addr[7:0]];
  always @(posedge clk) if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;

  // vector: req(4) op(2: 1 write, 2 read) word(1) addr(24) data(16) exp(16)
  // write exp = {5'b0, busreq, reset_n, bank[8:0]}
  function automatic logic [62:0] v(input int req, input int op, input bit word,
                                    input logic [23:0] a, input logic [15:0] d,
                                    input logic [15:0] e);
    return {4'(req), 2'(op), word, a, d, e};
  endfunction

  localparam int NV = 22;
  localparam logic [62:0] VEC [NV] = '{
    v(2, 1, 0, 24'hA11100, 16'h0001, 16'h0400),  // R2 halt, byte
    v(3, 2, 0, 24'hA11100, 16'h0000, 16'h8000),  // R3 halted status
    v(4, 1, 1, 24'hA11200, 16'h0100, 16'h0600),  // R4 release, word
    v(5, 1, 0, 24'hA06000, 16'h0001, 16'h0700),  // R5
    v(5, 1, 1, 24'hA06000, 16'h0001, 16'h0780),  // R5 word
    v(6, 1, 0, 24'hA0E0FF, 16'h0000, 16'h06C0),  // R6 mirror
    v(9, 1, 0, 24'hA00010, 16'h005A, 16'h06C0),  // R9 byte store
    v(10,2, 0, 24'hA00010, 16'h0000, 16'h5A5A),  // R10 halted read
    v(9, 1, 1, 24'hA02011, 16'hA53C, 16'h06C0),  // R9 word stores upper
    v(7, 2, 0, 24'hA00011, 16'h0000, 16'hA5A5),  // R7 alias
    v(11,2, 0, 24'hA07000, 16'h0000, 16'hFFFF),  // R11
    v(11,2, 0, 24'hA04000, 16'h0000, 16'h0000),  // R11
    v(2, 1, 1, 24'hA11100, 16'h0000, 16'h02C0),  // R2 run, word
    v(3, 2, 1, 24'hA11100, 16'h0000, 16'h8100),  // R3 running status
    v(10,2, 0, 24'hA00010, 16'h0000, 16'h0000),  // R10 running read
    v(8, 1, 0, 24'hA00010, 16'h0011, 16'h02C0),  // R8 dropped
    v(2, 1, 1, 24'hA11100, 16'h0100, 16'h06C0),  // R2 halt, word
    v(8, 2, 0, 24'hA00010, 16'h0000, 16'h5A5A),  // R8 byte unchanged
    v(4, 1, 0, 24'hA11200, 16'h0000, 16'h04C0),  // R4 assert reset
    v(11,2, 1, 24'hA0FFFE, 16'h0000, 16'hFFFF),  // R11 top of fill
    v(11,2, 1, 24'hA10000, 16'h0000, 16'h0000),  // R11 outside
    v(6, 1, 0, 24'hA06100, 16'h0001, 16'h04C0)   // R6 miss on bit 8
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] state_word();
    return {5'b0, z80_busreq, z80_reset_n, z80_bank};
  endfunction

  task automatic do_write(input logic [23:0] a, input logic [15:0] d, input bit word);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_word = word; host_wr = 1'b1;
    @(posedge clk); #5;
    host_wr = 1'b0;
  endtask

  task automatic do_read(input logic [23:0] a, input bit word, output logic [15:0] r);
    @(negedge clk);
    host_addr = a; host_word = word; host_rd = 1'b1;
    #5 r = host_rdata;
    host_rd = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] r;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    // R1 reset state
    check("R1 reset state", state_word(), 16'h0000);
    do_read(24'hA11100, 1'b0, r);
    check("R1 status after reset", r, 16'h8100);

    for (int i = 0; i < NV; i++) begin
      logic [62:0] e;
      string tag;
      e = VEC[i];
      tag = $sformatf("R%0d vector %0d", e[62:59], i);
      if (e[58:57] == 2'd1) begin
        do_write(e[55:32], e[31:16], e[56]);
        check(tag, state_word(), e[15:0]);
      end else begin
        do_read(e[55:32], e[56], r);
        check(tag, r, e[15:0]);
      end
    end

    // R7 address bits at the port, and R9 write strobe while halted
    @(negedge clk);
    host_addr = 24'hA02ABC; host_wdata = 16'h7700; host_word = 1'b1; host_wr = 1'b1;
    #5;
    check("R7 ram_addr low bits", {3'b0, ram_addr}, 16'h0ABC);
    check("R9 ram_we halted", {15'b0, ram_we}, 16'h0001);
    check("R9 word upper byte", {8'h00, ram_wdata}, 16'h0077);
    host_wr = 1'b0;
    // R8 strobe stays low while running
    do_write(24'hA11100, 16'h0000, 1'b0);
    @(negedge clk);
    host_addr = 24'hA00020; host_wdata = 16'h0099; host_word = 1'b0; host_wr = 1'b1;
    #5;
    check("R8 ram_we running", {15'b0, ram_we}, 16'h0000);
    host_wr = 1'b0;
    // R11 no read strobe
    @(negedge clk);
    host_addr = 24'hA07000; host_rd = 1'b0;
    #5 check("R11 idle read", host_rdata, 16'h0000);
    // R1 reset again
    do_write(24'hA06000, 16'h0001, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #5 rst_n = 1'b1;
    check("R1 second reset", state_word(), 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule